// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional buses, side A and side B, through a parallel set of identical bit lanes (eight by default). Each direction owns a storage register with its own capture strobe. A capture strobe loads its register from the bus it faces, whatever state the enables and selects are in. On the driving side, a select chooses between the live value on the opposite bus and the value held in that direction's register.

The B side is driven when its enable is high. The A side is driven when its enable is low. Each bus is split into an input sample, an output value and an output enable, so the surrounding logic (or a bench) resolves the tristate line. When both sides are driven with both selects at live, the two outputs would feed each other. The block then holds both buses at the value the A bus carried at the last clock before that mode began. With the B enable low and the A enable high, neither side drives, but both registers still load.

The capture strobes are sampled by the block clock. A register loads on the first clock where its strobe is seen high after having been seen low.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rstN` is low, `aOe` and `bOe` are 0 and both registers are cleared. After release, reading either register in stored mode returns 0 until it is loaded.
- R2: At a clock edge where `capAbClk` is sampled 1 and was sampled 0 at the previous edge, the A-to-B register loads the value on the A bus. This happens for any enable or select setting.
- R3: At a clock edge where `capBaClk` is sampled 1 and was sampled 0 at the previous edge, the B-to-A register loads the value on the B bus. This happens for any enable or select setting.
- R4: `bOe` is 1 exactly when `enAB` is 1. `aOe` is 1 exactly when `enBAn` is 0 (active low).
- R5: With `bOe` set and `selAB` = 0 (live), `bOut` equals the A bus in the same cycle. With `selAB` = 1 (stored), `bOut` equals the A-to-B register.
- R6: With `aOe` set and `selBA` = 0 (live), `aOut` equals the B bus in the same cycle. With `selBA` = 1 (stored), `aOut` equals the B-to-A register.
- R7: With `enAB` = 0 and `enBAn` = 1, neither bus is driven, and both registers still load on their capture strobes.
- R8: With `enAB` = 1, `enBAn` = 0 and both selects at 1, the B bus carries the A-to-B register and the A bus carries the B-to-A register, both at once.
- R9: With `enAB` = 1, `enBAn` = 0 and both selects at 0, both outputs are driven with the A bus value seen at the last clock before the mode began. That value is held, unchanged, for as long as the mode lasts.
- R10: While the A side drives the stored B-to-A value, a capture on `capAbClk` copies that value into the A-to-B register, so both registers hold the same data.
- R11: When the live and stored values of a direction are equal, toggling its select leaves that direction's output value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples the capture strobes |
| rstN | input | 1 | Asynchronous active-low reset |
| capAbClk | input | 1 | Capture strobe for the A-to-B register |
| capBaClk | input | 1 | Capture strobe for the B-to-A register |
| enAB | input | 1 | B-side drive enable, active high |
| enBAn | input | 1 | A-side drive enable, active low |
| selAB | input | 1 | B-side source: 0 live A bus, 1 stored register |
| selBA | input | 1 | A-side source: 0 live B bus, 1 stored register |
| aIn | input | WIDTH | Resolved A bus sample |
| aOut | output | WIDTH | Value offered to the A bus |
| aOe | output | 1 | A-side output enable |
| bIn | input | WIDTH | Resolved B bus sample |
| bOut | output | WIDTH | Value offered to the B bus |
| bOe | output | 1 | B-side output enable |

## Verification
The assertions check on every cycle:
- The enable polarities and the quiet outputs during reset.
- The live and stored routing on each side against the bus samples and the registers.
- That every detected strobe edge loads its register with the bus value from that edge.
- That the held value in the bus-hold mode stays stable and equal on both sides.

Only the bench scenarios can show the following, because each needs a sequence of modes:
- That isolation still loads both registers.
- That a stored value driven onto A is copied into the other register.
- Which bus value the hold mode keeps on entry.
- That a select toggle between equal values leaves the output unchanged.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;

  // Strobes from control to the lane datapath.
  typedef struct packed {
    logic capAb;        // load A-to-B register this edge
    logic capBa;        // load B-to-A register this edge
    logic pickStoredB;  // B output takes stored data
    logic pickStoredA;  // A output takes stored data
    logic holdLoop;     // both sides live-driven: hold mode
  } xcvrStrobe_t;

endpackage

// File: rtl/regbus_xcvr_ctrl.sv
module regbus_xcvr_ctrl
  import regbus_xcvr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        capAbClk,
  input  logic        capBaClk,
  input  logic        enAB,
  input  logic        enBAn,
  input  logic        selAB,
  input  logic        selBA,
  output xcvrStrobe_t strobe,
  output logic        aOe,
  output logic        bOe
);

  localparam int NUM_CAP = 2;

  logic [NUM_CAP-1:0] capRaw;
  logic [NUM_CAP-1:0] capPrev;
  logic [NUM_CAP-1:0] capEdge;

  assign capRaw = {capBaClk, capAbClk};

  // One edge detector per capture strobe.
  for (genvar g = 0; g < NUM_CAP; g++) begin : gCapEdge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) capPrev[g] <= 1'b0;
      else       capPrev[g] <= capRaw[g];
    end
    assign capEdge[g] = capRaw[g] & ~capPrev[g];
  end

  logic driveA;
  logic driveB;

  // Output enables depend only on their enable pin and reset.
  assign driveB = rstN & enAB;
  assign driveA = rstN & ~enBAn;
  assign bOe    = driveB;
  assign aOe    = driveA;

  always_comb begin
    strobe.capAb       = capEdge[0];
    strobe.capBa       = capEdge[1];
    strobe.pickStoredB = selAB;
    strobe.pickStoredA = selBA;
    strobe.holdLoop    = driveA & driveB & ~selAB & ~selBA;
  end

endmodule

// File: rtl/regbus_xcvr_lane.sv
module regbus_xcvr_lane
  import regbus_xcvr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  xcvrStrobe_t strobe,
  input  logic        aBit,
  input  logic        bBit,
  output logic        aDrv,
  output logic        bDrv,
  output logic        abQ,
  output logic        baQ
);

  logic holdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      abQ   <= 1'b0;
      baQ   <= 1'b0;
      holdQ <= 1'b0;
    end else begin
      if (strobe.capAb)     abQ   <= aBit;
      if (strobe.capBa)     baQ   <= bBit;
      if (!strobe.holdLoop) holdQ <= aBit;
    end
  end

  // Select mux with a consensus term: equal inputs give a steady output.
  logic bSel;
  logic aSel;

  assign bSel = (strobe.pickStoredB & abQ) | (~strobe.pickStoredB & aBit) | (abQ & aBit);
  assign aSel = (strobe.pickStoredA & baQ) | (~strobe.pickStoredA & bBit) | (baQ & bBit);

  assign bDrv = strobe.holdLoop ? holdQ : bSel;
  assign aDrv = strobe.holdLoop ? holdQ : aSel;

endmodule

// File: rtl/regbus_xcvr_datapath.sv
module regbus_xcvr_datapath
  import regbus_xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  xcvrStrobe_t      strobe,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] bOut,
  output logic [WIDTH-1:0] storedAb,
  output logic [WIDTH-1:0] storedBa
);

  for (genvar ch = 0; ch < WIDTH; ch++) begin : gLane
    regbus_xcvr_lane lane_i (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (strobe),
      .aBit   (aIn[ch]),
      .bBit   (bIn[ch]),
      .aDrv   (aOut[ch]),
      .bDrv   (bOut[ch]),
      .abQ    (storedAb[ch]),
      .baQ    (storedBa[ch])
    );
  end

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import regbus_xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             capAbClk,
  input  logic             capBaClk,
  input  logic             enAB,
  input  logic             enBAn,
  input  logic             selAB,
  input  logic             selBA,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOe
);

  xcvrStrobe_t      strobe;
  logic [WIDTH-1:0] storedAb;
  logic [WIDTH-1:0] storedBa;

  regbus_xcvr_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .capAbClk (capAbClk),
    .capBaClk (capBaClk),
    .enAB     (enAB),
    .enBAn    (enBAn),
    .selAB    (selAB),
    .selBA    (selBA),
    .strobe   (strobe),
    .aOe      (aOe),
    .bOe      (bOe)
  );

  regbus_xcvr_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .aIn      (aIn),
    .bIn      (bIn),
    .aOut     (aOut),
    .bOut     (bOut),
    .storedAb (storedAb),
    .storedBa (storedBa)
  );

endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             capAbClk,
  input logic             capBaClk,
  input logic             enAB,
  input logic             enBAn,
  input logic             selAB,
  input logic             selBA,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] aOut,
  input logic             aOe,
  input logic [WIDTH-1:0] bIn,
  input logic [WIDTH-1:0] bOut,
  input logic             bOe,
  input logic [WIDTH-1:0] storedAb,
  input logic [WIDTH-1:0] storedBa
);

  logic loopNow;
  assign loopNow = aOe & bOe & ~selAB & ~selBA;

  always_comb begin
    if (!rstN) begin
      a_r1_reset_quiet: assert (!aOe && !bOe);
    end
  end

  a_r4_b_enable: assert property (@(posedge clk) disable iff (!rstN)
    bOe == enAB);

  a_r4_a_enable: assert property (@(posedge clk) disable iff (!rstN)
    aOe == !enBAn);

  a_r7_isolated: assert property (@(posedge clk) disable iff (!rstN)
    (!enAB && enBAn) |-> (!aOe && !bOe));

  a_r2_capture: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capAbClk) |=> storedAb == $past(aIn));

  a_r3_capture: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capBaClk) |=> storedBa == $past(bIn));

  a_r5_live_b: assert property (@(posedge clk) disable iff (!rstN)
    (bOe && !selAB && !loopNow) |-> bOut == aIn);

  a_r6_live_a: assert property (@(posedge clk) disable iff (!rstN)
    (aOe && !selBA && !loopNow) |-> aOut == bIn);

  a_r8_stored_b: assert property (@(posedge clk) disable iff (!rstN)
    (bOe && selAB) |-> bOut == storedAb);

  a_r8_stored_a: assert property (@(posedge clk) disable iff (!rstN)
    (aOe && selBA) |-> aOut == storedBa);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (loopNow && $past(loopNow)) |-> ($stable(aOut) && aOut == bOut));

endmodule

bind regbus_xcvr regbus_xcvr_chk #(.WIDTH(WIDTH)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .capAbClk (capAbClk),
  .capBaClk (capBaClk),
  .enAB     (enAB),
  .enBAn    (enBAn),
  .selAB    (selAB),
  .selBA    (selBA),
  .aIn      (aIn),
  .aOut     (aOut),
  .aOe      (aOe),
  .bIn      (bIn),
  .bOut     (bOut),
  .bOe      (bOe),
  .storedAb (storedAb),
  .storedBa (storedBa)
);

// File: tb/regbus_xcvr_tb_top.sv
module regbus_xcvr_tb_top;

  localparam int W      = 8;
  localparam int PERIOD = 10;

  logic         clk      = 1'b0;
  logic         rstN     = 1'b0;
  logic         capAbClk = 1'b0;
  logic         capBaClk = 1'b0;
  logic         enAB     = 1'b0;
  logic         enBAn    = 1'b1;
  logic         selAB    = 1'b0;
  logic         selBA    = 1'b0;
  logic [W-1:0] extA     = '0;
  logic [W-1:0] extB     = '0;
  logic         extEnA   = 1'b1;
  logic         extEnB   = 1'b1;

  logic [W-1:0] aOut, bOut;
  logic         aOe, bOe;
  wire  [W-1:0] busA;
  wire  [W-1:0] busB;

  // Wired tristate resolution of both buses.
  assign #1 busA = aOe ? aOut : extA;
  assign #1 busB = bOe ? bOut : extB;

  always #(PERIOD/2) clk = ~clk;

  regbus_xcvr #(.WIDTH(W)) dut_i (
    .clk(clk), .rstN(rstN), .capAbClk(capAbClk), .capBaClk(capBaClk),
    .enAB(enAB), .enBAn(enBAn), .selAB(selAB), .selBA(selBA),
    .aIn(busA), .aOut(aOut), .aOe(aOe),
    .bIn(busB), .bOut(bOut), .bOe(bOe)
  );

  int    checks = 0;
  int    fails  = 0;
  string curTag = "R1";

  // Behavioural reference state.
  logic [W-1:0] mAb = '0, mBa = '0, mHold = '0;
  logic         mPrevAb = 1'b0, mPrevBa = 1'b0;

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic inLoop();
    return rstN && enAB && !enBAn && !selAB && !selBA;
  endfunction

  task automatic resolveModel(output logic [W-1:0] av, output logic [W-1:0] bv);
    logic drvA, drvB;
    drvA = rstN && !enBAn;
    drvB = rstN && enAB;
    if (inLoop()) begin
      av = mHold; bv = mHold;
    end else if (drvA && !selBA) begin
      bv = drvB ? mAb : extB;
      av = bv;
    end else begin
      av = drvA ? mBa : extA;
      bv = drvB ? (selAB ? mAb : av) : extB;
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAb = '0; mBa = '0; mHold = '0; mPrevAb = 1'b0; mPrevBa = 1'b0;
    end else begin
      logic [W-1:0] av, bv;
      resolveModel(av, bv);
      if (capAbClk && !mPrevAb) mAb = av;
      if (capBaClk && !mPrevBa) mBa = bv;
      mPrevAb = capAbClk;
      mPrevBa = capBaClk;
      if (!inLoop()) mHold = av;
    end
  end

  // Compare against the model on every cycle, away from the active edge.
  always @(negedge clk) begin
    logic [W-1:0] av, bv;
    logic expAOe, expBOe;
    resolveModel(av, bv);
    expAOe = rstN && !enBAn;
    expBOe = rstN && enAB;
    check(curTag, "aOe", {{(W-1){1'b0}}, aOe}, {{(W-1){1'b0}}, expAOe});
    check(curTag, "bOe", {{(W-1){1'b0}}, bOe}, {{(W-1){1'b0}}, expBOe});
    if (expAOe) check(curTag, "aOut", aOut, av);
    if (expBOe) check(curTag, "bOut", bOut, bv);
    if (aOe && extEnA && aOut !== extA) check(curTag, "contention A", aOut, extA);
    if (bOe && extEnB && bOut !== extB) check(curTag, "contention B", bOut, extB);
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic setMode(input logic eAB, input logic eBAn,
                         input logic sAB, input logic sBA);
    enAB = eAB; enBAn = eBAn; selAB = sAB; selBA = sBA;
    extEnA = eBAn;
    extEnB = !eAB;
  endtask

  task automatic pulseAb();
    capAbClk = 1'b1; step(1); capAbClk = 1'b0; step(1);
  endtask

  task automatic pulseBa();
    capBaClk = 1'b1; step(1); capBaClk = 1'b0; step(1);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    finishRun();
  end

  initial begin
    // R1: outputs quiet in reset even with enables asserted
    curTag = "R1";
    setMode(1'b1, 1'b0, 1'b1, 1'b1);
    extA = 8'h11; extB = 8'h22;
    capAbClk = 1'b1; capBaClk = 1'b1;
    step(3);
    capAbClk = 1'b0; capBaClk = 1'b0;
    #2;
    check("R1", "aOe in reset", {7'b0, aOe}, 8'h00);
    check("R1", "bOe in reset", {7'b0, bOe}, 8'h00);
    rstN = 1'b1;
    step(2);
    check("R1", "stored B after reset", bOut, 8'h00);
    check("R1", "stored A after reset", aOut, 8'h00);

    // R4: enable polarity
    curTag = "R4";
    setMode(1'b0, 1'b0, 1'b1, 1'b1); step(2);
    setMode(1'b1, 1'b1, 1'b1, 1'b1); step(2);

    // R5: live A to B under several patterns
    curTag = "R5";
    setMode(1'b1, 1'b1, 1'b0, 1'b0);
    extA = 8'hA5; step(1);
    extA = 8'h3C; step(1);
    extA = 8'hFF; step(1);
    check("R5", "live B", bOut, 8'hFF);

    // R2: capture while driving live, then read stored
    curTag = "R2";
    extA = 8'h5A; pulseAb();
    extA = 8'h0F; selAB = 1'b1; step(2);
    check("R2", "stored B", bOut, 8'h5A);
    // capture regardless of enables and selects
    setMode(1'b0, 1'b1, 1'b0, 1'b1);
    extA = 8'h81; pulseAb();
    setMode(1'b1, 1'b1, 1'b1, 1'b0); step(1);
    check("R2", "stored B with disabled capture", bOut, 8'h81);

    // R6 / R3: B to A
    curTag = "R6";
    setMode(1'b0, 1'b0, 1'b0, 1'b0);
    extB = 8'h69; step(1);
    extB = 8'h96; step(1);
    check("R6", "live A", aOut, 8'h96);
    curTag = "R3";
    extB = 8'hC3; pulseBa();
    extB = 8'h00; selBA = 1'b1; step(2);
    check("R3", "stored A", aOut, 8'hC3);

    // R7: isolation, registers still load
    curTag = "R7";
    setMode(1'b0, 1'b1, 1'b1, 1'b1);
    extA = 8'h24; extB = 8'hDB;
    capAbClk = 1'b1; capBaClk = 1'b1; step(1);
    capAbClk = 1'b0; capBaClk = 1'b0; step(2);
    check("R7", "aOe isolated", {7'b0, aOe}, 8'h00);
    check("R7", "bOe isolated", {7'b0, bOe}, 8'h00);

    // R8: both stored at once
    curTag = "R8";
    setMode(1'b1, 1'b0, 1'b1, 1'b1); step(2);
    check("R8", "B from A reg", bOut, 8'h24);
    check("R8", "A from B reg", aOut, 8'hDB);

    // R10: A drives stored B data, A-to-B capture copies it
    curTag = "R10";
    setMode(1'b0, 1'b0, 1'b1, 1'b1);
    pulseAb();
    setMode(1'b1, 1'b0, 1'b1, 1'b1); step(1);
    check("R10", "copied register", bOut, 8'hDB);

    // R11: equal live and stored; select toggle keeps output
    curTag = "R11";
    setMode(1'b1, 1'b1, 1'b1, 1'b0);
    extA = 8'hDB; step(1);
    for (int i = 0; i < 6; i++) begin
      selAB = ~selAB; #2;
      check("R11", "bOut steady", bOut, 8'hDB);
      step(1);
    end

    // R9: enter bus-hold from live A to B
    curTag = "R9";
    setMode(1'b1, 1'b1, 1'b0, 1'b0);
    extA = 8'h96; step(2);
    setMode(1'b1, 1'b0, 1'b0, 1'b0);
    extA = 8'h00; extB = 8'h00;
    step(4);
    check("R9", "held A", aOut, 8'h96);
    check("R9", "held B", bOut, 8'h96);
    setMode(1'b0, 1'b1, 1'b0, 1'b0);
    step(2);

    finishRun();
  end

endmodule